// File: doc/BRIEF.md
# Serial configuration memory reader

This block is the read path of a serial memory that holds an FPGA bitstream and streams it out one bit per clock. While the device is selected, set to read mode and not held in reset, each rising clock edge moves a single bit pointer forward. The pointer walks every stored byte from its most significant bit down to its least significant bit. The bit under the pointer appears on a data output. That output is modelled as a value plus a separate drive enable, which stands in for a three-state pin.

A shared pin acts as the counter reset at one level and as output enable at the other level. A parameter selects which level means reset. When the last stored bit has been clocked out, an active-low cascade output is asserted so that the next memory in a chain can continue the stream. That output is released when the host returns the shared pin to its reset level. After power-on reset, a ready flag stays low for a set number of cycles. A serial-enable input selects between read mode and programming mode; in programming mode the reader stays idle.

The stored contents are generated from the byte address, so even the default 2-megabit capacity needs no storage array.

Top module: `cfgrd_reader`

## Requirements
- R1: While ready, with `ser_en` high, `ce_n` low and `rst_oe` at its output-enable level, and before the final bit has been read, every rising clock edge advances the bit pointer by exactly one. Bits within a byte are presented most significant bit first, and byte addresses increase.
- R2: `data_oe` is high only when all four of these hold: `ready` is high, `ser_en` is high, `ce_n` is low, and `rst_oe` is at its output-enable level. In every other case it is low.
- R3: When `rst_oe` is at its reset level (`ser_en` high, `ready` high) on a clock edge, the pointer returns to bit 0 of byte 0. This happens whatever the level of `ce_n`.
- R4: With `ce_n` high the pointer does not move and `data_oe` is low, whatever `rst_oe` is at its output-enable level.
- R5: `ceo_n` is high while the stream is in progress. It goes low right after the clock edge that consumes the last stored bit. From then on the pointer rests at bit 0 and does not advance until `rst_oe` is taken to its reset level.
- R6: Once the stream is finished, `ceo_n` equals `ce_n` while `rst_oe` stays at its output-enable level. It is high whenever `rst_oe` is at its reset level. After that reset it stays high until the whole memory has been read again.
- R7: With `ser_en` low, `data_oe` is low, the pointer holds its value, and neither `ce_n` nor `rst_oe` has any effect.
- R8: With `RST_ACTIVE_HIGH` = 1, a high level on `rst_oe` is the reset level and a low level enables the output. With `RST_ACTIVE_HIGH` = 0, the two meanings are swapped.
- R9: The byte at address `a` holds `(a*PAT_MUL + PAT_ADD) mod 256`. The capacity is `CAP_BYTES` bytes, and the default of 262144 gives 2 megabits.
- R10: After `rst_n` is released, `ready` stays low for exactly `POR_CYCLES` rising edges and then goes high. While `ready` is low, `data_oe` is low and the pointer stays at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; rising edges advance the bit pointer |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_en | input | 1 | High selects read mode; low selects programming mode |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| rst_oe | input | 1 | Shared counter reset / output enable; polarity set by `RST_ACTIVE_HIGH` |
| data_out | output | 1 | Stored bit at the current pointer position |
| data_oe | output | 1 | Drive enable for `data_out`; low stands for high impedance |
| ceo_n | output | 1 | Active-low cascade enable for the next device in a chain |
| ready | output | 1 | High once the power-on delay has elapsed |

## Verification
The bench builds two instances with `CAP_BYTES` = 4 and `POR_CYCLES` = 3. With these values the final bit is reached after 32 clocks, so the complete cascade sequence can be exercised: the end of the stream, `ceo_n` following `ce_n`, release on reset, and a full second pass. The two instances differ only in `RST_ACTIVE_HIGH` and are driven with inverted `rst_oe`, so every read, standby and reset case checks both polarities at the same moment. `PAT_MUL` = 37 and `PAT_ADD` = 0xB4 make the four-bit windows at pointer positions 0, 1 and 2 all different. This lets a short read after each stimulus reveal whether the pointer was cleared, held or advanced.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

    // Cascade phase of the reader: stream still running, or stream finished
    typedef enum logic {
        CAS_ARMED = 1'b0,
        CAS_SPENT = 1'b1
    } cas_e;

endpackage

// File: rtl/cfgrd_pattern.sv
// Generates the stored byte for an address from a linear formula
module cfgrd_pattern #(
    parameter int          ADDR_W  = 18,
    parameter int unsigned PAT_MUL = 37,
    parameter int unsigned PAT_ADD = 180
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        byte_val
);

    always_comb begin
        byte_val = 8'(32'(addr) * PAT_MUL + PAT_ADD);
    end

endmodule

// File: rtl/cfgrd_por.sv
// Power-on delay counter that drives the ready flag
module cfgrd_por #(
    parameter int POR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int CNT_W = (POR_CYCLES < 1) ? 1 : $clog2(POR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POR_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CNT_END) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == CNT_END);

endmodule

// File: rtl/cfgrd_reader.sv
// Read path of a serial configuration memory
module cfgrd_reader
    import cfgrd_pkg::*;
#(
    parameter int          CAP_BYTES       = 262144,
    parameter int          POR_CYCLES      = 16,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    parameter int unsigned PAT_MUL         = 37,
    parameter int unsigned PAT_ADD         = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en,
    input  logic ce_n,
    input  logic rst_oe,
    output logic data_out,
    output logic data_oe,
    output logic ceo_n,
    output logic ready
);

    localparam int TOTAL_BITS = CAP_BYTES * 8;
    localparam int POS_W      = $clog2(TOTAL_BITS);
    localparam int ADDR_W     = POS_W - 3;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOTAL_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        cas_e             cas;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic             reset_lvl;
    logic             run_mode;
    logic [7:0]       cur_byte;
    logic [POS_W-1:0] pos_q;
    logic             spent_q;

    cfgrd_por #(
        .POR_CYCLES(POR_CYCLES)
    ) u_por (
        .clk  (clk),
        .rst_n(rst_n),
        .ready(ready)
    );

    cfgrd_pattern #(
        .ADDR_W (ADDR_W),
        .PAT_MUL(PAT_MUL),
        .PAT_ADD(PAT_ADD)
    ) u_pat (
        .addr    (st_q.pos[POS_W-1:3]),
        .byte_val(cur_byte)
    );

    assign reset_lvl = (rst_oe == RST_ACTIVE_HIGH);
    assign run_mode  = ready && ser_en;

    always_comb begin
        st_d = st_q;
        if (run_mode) begin
            if (reset_lvl) begin
                st_d.pos = '0;
                st_d.cas = CAS_ARMED;
            end else if (!ce_n && st_q.cas == CAS_ARMED) begin
                if (st_q.pos == LAST_POS) begin
                    st_d.pos = '0;
                    st_d.cas = CAS_SPENT;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: '0, cas: CAS_ARMED};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q    = st_q.pos;
    assign spent_q  = (st_q.cas == CAS_SPENT);
    assign data_out = cur_byte[3'(~st_q.pos[2:0])];
    assign data_oe  = run_mode && !ce_n && !reset_lvl;
    assign ceo_n    = !(run_mode && spent_q && !ce_n && !reset_lvl);

endmodule

// File: rtl/cfgrd_reader_chk.sv
// Property checker attached to the reader
module cfgrd_reader_chk #(
    parameter int POS_W           = 21,
    parameter int TOTAL_BITS      = 2097152,
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_en,
    input logic             ce_n,
    input logic             rst_oe,
    input logic             data_oe,
    input logic             ceo_n,
    input logic             ready,
    input logic [POS_W-1:0] pos_q,
    input logic             spent_q
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOTAL_BITS - 1);

    // R2
    drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (ready && ser_en && !ce_n && (rst_oe != RST_ACTIVE_HIGH)));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ser_en && (rst_oe == RST_ACTIVE_HIGH)) |=> (pos_q == '0 && !spent_q));

    // R4
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ser_en && ce_n && (rst_oe != RST_ACTIVE_HIGH)) |=> $stable(pos_q));

    // R5
    stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ser_en && !ce_n && (rst_oe != RST_ACTIVE_HIGH) && !spent_q && pos_q == LAST_POS)
        |=> (spent_q && pos_q == '0));

    // R6
    cascade_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_oe == RST_ACTIVE_HIGH) |-> ceo_n);

    // R7
    prog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> ($stable(pos_q) && $stable(spent_q)));

    // R10
    not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!data_oe && pos_q == '0));

endmodule

bind cfgrd_reader cfgrd_reader_chk #(
    .POS_W          (POS_W),
    .TOTAL_BITS     (TOTAL_BITS),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_en (ser_en),
    .ce_n   (ce_n),
    .rst_oe (rst_oe),
    .data_oe(data_oe),
    .ceo_n  (ceo_n),
    .ready  (ready),
    .pos_q  (pos_q),
    .spent_q(spent_q)
);

// File: tb/sim_cfgrd_reader.sv
module sim_cfgrd_reader;

    localparam int CLK_PERIOD = 10;
    localparam int CAP       = 4;
    localparam int POR       = 3;
    localparam int NBITS     = CAP * 8;
    localparam int MUL       = 37;
    localparam int ADD       = 180;

    // {ser_en, ce_n, rst_oe(high = reset for u0), exp_oe, exp_pos[1:0]}
    localparam logic [5:0] VEC [8] = '{
        6'b100110, 6'b101000, 6'b110001, 6'b111000,
        6'b000001, 6'b001001, 6'b010001, 6'b011001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b1;
    logic ce_n = 1'b0;
    logic rst_oe = 1'b0;
    logic d0, oe0, ceo0, rdy0;
    logic d1, oe1, ceo1, rdy1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgrd_reader #(
        .CAP_BYTES(CAP), .POR_CYCLES(POR), .RST_ACTIVE_HIGH(1'b1),
        .PAT_MUL(MUL), .PAT_ADD(ADD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(rst_oe),
        .data_out(d0), .data_oe(oe0), .ceo_n(ceo0), .ready(rdy0)
    );

    cfgrd_reader #(
        .CAP_BYTES(CAP), .POR_CYCLES(POR), .RST_ACTIVE_HIGH(1'b0),
        .PAT_MUL(MUL), .PAT_ADD(ADD)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(~rst_oe),
        .data_out(d1), .data_oe(oe1), .ceo_n(ceo1), .ready(rdy1)
    );

    function automatic logic exp_bit(input int p);
        int a;
        logic [7:0] b;
        a = (p % NBITS) / 8;
        b = 8'((a * MUL + ADD) % 256);
        return b[7 - (p % 8)];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock, then settle away from the edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic read_nib(input int start, input string req);
        logic [3:0] got, gotb, want;
        for (int i = 0; i < 4; i++) begin
            got[3 - i]  = d0;
            gotb[3 - i] = d1;
            want[3 - i] = exp_bit(start + i);
            tick();
        end
        chk(req, int'(got), int'(want));
        chk({req, " R8"}, int'(gotb), int'(want));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state
        tick();
        tick();
        chk("R10 reset oe", int'(oe0), 0);
        chk("R10 reset ready", int'(rdy0), 0);
        chk("R5 reset ceo", int'(ceo0), 1);
        rst_n = 1'b1;
        for (int i = 0; i < POR - 1; i++) begin
            tick();
            chk("R10 ready low", int'(rdy0), 0);
            chk("R10 oe low", int'(oe0), 0);
        end
        tick();
        chk("R10 ready high", int'(rdy0), 1);
        chk("R10 ready high u1", int'(rdy1), 1);

        // full stream, first pass (R1, R9)
        for (int p = 0; p < NBITS; p++) begin
            chk("R1 R9 bit", int'(d0), int'(exp_bit(p)));
            chk("R8 bit u1", int'(d1), int'(exp_bit(p)));
            chk("R2 oe on", int'(oe0), 1);
            chk("R5 ceo high", int'(ceo0), 1);
            tick();
        end
        chk("R5 ceo low after end", int'(ceo0), 0);
        chk("R8 ceo low u1", int'(ceo1), 0);
        tick();
        tick();
        chk("R5 still low", int'(ceo0), 0);
        chk("R5 pointer rests", int'(d0), int'(exp_bit(0)));

        // cascade phases (R6)
        ce_n = 1'b1;
        #1;
        chk("R6 follows ce high", int'(ceo0), 1);
        chk("R4 oe off", int'(oe0), 0);
        ce_n = 1'b0;
        #1;
        chk("R6 follows ce low", int'(ceo0), 0);
        rst_oe = 1'b1;
        #1;
        chk("R6 high on reset level", int'(ceo0), 1);
        tick();
        rst_oe = 1'b0;
        #1;
        chk("R6 stays high", int'(ceo0), 1);
        for (int p = 0; p < NBITS; p++) begin
            chk("R6 second pass bit", int'(d0), int'(exp_bit(p)));
            if (p == NBITS - 1) chk("R6 high before last edge", int'(ceo0), 1);
            tick();
        end
        chk("R6 low after second pass", int'(ceo0), 0);

        // vector table (R2, R3, R4, R7, R8)
        for (int v = 0; v < 8; v++) begin
            string tag;
            ser_en = 1'b1; ce_n = 1'b0; rst_oe = 1'b1;
            tick();
            rst_oe = 1'b0;
            tick();
            {ser_en, ce_n, rst_oe} = VEC[v][5:3];
            #1;
            chk("R2 vector oe", int'(oe0), int'(VEC[v][2]));
            chk("R8 vector oe u1", int'(oe1), int'(VEC[v][2]));
            tick();
            if (!VEC[v][5])      tag = "R7 prog hold";
            else if (VEC[v][3])  tag = "R3 clear";
            else if (VEC[v][4])  tag = "R4 standby hold";
            else                 tag = "R1 advance";
            ser_en = 1'b1; ce_n = 1'b0; rst_oe = 1'b0;
            #1;
            read_nib(int'(VEC[v][1:0]), tag);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule